// File: doc/BRIEF.md
# Serial Audio Port Transfer Controller

This block is the control core of a serial audio port. Software or a DMA engine reaches it through a 32-bit word register bus. Behind the bus it holds a set of transmit sample FIFOs, called lanes, and one receive sample FIFO. Words written to the transmit data register are spread over the lanes in turn. The serial side empties the lanes one frame at a time: each pulse of its consumption strobe removes one word from every lane together. The serial side also delivers received words on a production strobe, and those words are read back from the receive data register. Bit formatting and clock division sit outside the block. It sees only the two strobes.

Transmit and receive each have their own start bit. Each direction also has a clear bit that flushes its FIFO. The clear bit stays at 1 until the flush has finished, so software polls it. DMA requests and interrupt conditions come from comparing FIFO levels with programmable thresholds. Every threshold is stored as the level minus one. Transmit underrun and receive overflow are sticky status flags that software clears by writing a 1 to a clear bit.

Top module: `afc_core`

## Requirements
- R1: The registers sit on a 4-byte stride, and any other address reads 0.
  - Transmit control (0x00), receive control (0x04) and clock control (0x08) are plain 32-bit storage and read back what was written.
  - DMA control (0x10) reads back only its fields: transmit code [4:0], transmit enable bit 8, receive code [20:16], receive enable bit 24.
  - Interrupt control (0x14) reads back only its fields: transmit-empty enable bit 0, underrun enable bit 1, transmit threshold [8:4], receive-full enable bit 16, overflow enable bit 17, receive threshold [24:20]. Its clear bits 2 and 18 read back as 0.
  - Transmit data (0x24) reads 0.
- R2: Transfer start (0x1C) holds transmit run at bit 0 and receive run at bit 1, and reads back. While transmit is stopped, the consumption strobe neither pops a lane nor flags underrun. While receive is stopped, production strobes are ignored.
- R3: Each accepted write to transmit data (0x24) goes to the next lane in turn, starting from lane 0 after reset or clear. The level register (0x0C) reports lane k's level in bits [6k+5:6k] and the receive level in bits [29:24]. It is read-only.
- R4: While transmit runs and the last lane is not empty, a consumption strobe pops one word from every lane. The head of lane k is presented on `tx_word[32k+31:32k]`.
- R5: A transmit data write whose target lane already holds 32 words is dropped. The lane pointer does not advance.
- R6: A read of receive data (0x28) returns the oldest received word and removes it. A read of an empty receive FIFO returns 0.
- R7: A received word that arrives while the receive FIFO holds 32 words and no pop happens is dropped, and status bit 17 (0x18) is set. The bit stays set until a 1 is written to interrupt-control bit 18.
- R8: A received word that arrives in the same cycle as a bus pop of a full receive FIFO is stored. The level stays 32 and no overflow is flagged.
- R9: A consumption strobe while transmit runs and the last lane is empty sets status bit 1 (underrun). The bit stays set until a 1 is written to interrupt-control bit 2.
- R10: The transmit DMA request is high while transmit DMA is enabled and the last lane's level is at or below code+1. The receive DMA request is high while receive DMA is enabled and the receive level is at or above code+1.
- R11: Status bit 0 is high when the last lane's level is at or below the transmit threshold+1. Status bit 16 is high when the receive level is at or above the receive threshold+1. `irq` is the OR of the four status bits (0, 1, 16, 17), each gated by its enable.
- R12: Writing 1 to clear bit 0 (transmit) or bit 1 (receive) at 0x20 empties that direction's FIFOs. The bit then reads 1 for exactly 4 cycles after the write and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (pops receive data at 0x28) |
| bus_rdata | output | 32 | Read data for the current address |
| tx_take | input | 1 | Consumption strobe from the serial side |
| tx_word | output | 128 | Head word of every transmit lane, lane k in bits [32k+31:32k] |
| rx_put | input | 1 | Production strobe from the serial side |
| rx_word | input | 32 | Received word qualified by `rx_put` |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq | output | 1 | Combined interrupt |

## Verification
The receive FIFO can be popped by the bus and filled by the serial side in the same cycle. When the FIFO is already full, that coincidence decides between a stored word and an overflow. The bench fills the receive FIFO to 32 words. It then raises a receive data read and a production strobe together. It expects the oldest word on the bus, a level that stays at 32 and an overflow flag that stays clear. Draining the FIFO must then end with the word that arrived during the pop. Underrun and its clear can also meet in one cycle; setting the flag takes priority over clearing it.

// File: rtl/afc_pkg.sv
package afc_pkg;

    localparam int DATA_W  = 32;
    localparam int CODE_W  = 5;

    // register byte offsets
    localparam int OFF_TXCTL  = 'h00;
    localparam int OFF_RXCTL  = 'h04;
    localparam int OFF_CKCTL  = 'h08;
    localparam int OFF_LEVEL  = 'h0C;
    localparam int OFF_DMA    = 'h10;
    localparam int OFF_INTCTL = 'h14;
    localparam int OFF_STATUS = 'h18;
    localparam int OFF_XFER   = 'h1C;
    localparam int OFF_CLEAR  = 'h20;
    localparam int OFF_TXDATA = 'h24;
    localparam int OFF_RXDATA = 'h28;

    typedef struct packed {
        logic              rx_en;
        logic [CODE_W-1:0] rx_code;
        logic              tx_en;
        logic [CODE_W-1:0] tx_code;
    } dma_cfg_t;

    typedef struct packed {
        logic [CODE_W-1:0] rx_thr;
        logic              ovf_ie;
        logic              full_ie;
        logic [CODE_W-1:0] tx_thr;
        logic              und_ie;
        logic              empty_ie;
    } irq_cfg_t;

    // level at or below threshold code + 1
    function automatic logic lvl_at_most(input logic [7:0] lvl, input logic [CODE_W-1:0] code);
        return lvl <= ({3'b000, code} + 8'd1);
    endfunction

    // level at or above threshold code + 1
    function automatic logic lvl_at_least(input logic [7:0] lvl, input logic [CODE_W-1:0] code);
        return lvl >= ({3'b000, code} + 8'd1);
    endfunction

    function automatic logic [DATA_W-1:0] pack_dma(input dma_cfg_t d);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[4:0]   = d.tx_code;
        w[8]     = d.tx_en;
        w[20:16] = d.rx_code;
        w[24]    = d.rx_en;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_irq(input irq_cfg_t c);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[0]     = c.empty_ie;
        w[1]     = c.und_ie;
        w[8:4]   = c.tx_thr;
        w[16]    = c.full_ie;
        w[17]    = c.ovf_ie;
        w[24:20] = c.rx_thr;
        return w;
    endfunction

endpackage

// File: rtl/afc_fifo.sv
module afc_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          accept
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_pop;

    assign empty  = (level == '0);
    assign full   = (level == LW'(DEPTH));
    assign do_pop = pop && !empty;
    // a pop in the same cycle frees the slot a push needs
    assign accept = push && (!full || do_pop);
    assign dout   = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (accept) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            level <= level + LW'(accept) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (accept && !rst && !flush) mem[wp] <= din;
    end

endmodule

// File: rtl/afc_clr_timer.sv
module afc_clr_timer #(
    parameter int CYCLES = 4,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (start)      cnt <= CW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/afc_flags.sv
module afc_flags
    import afc_pkg::*;
#(
    parameter int LW = 6
) (
    input  logic [LW-1:0] tx_lvl,
    input  logic [LW-1:0] rx_lvl,
    input  dma_cfg_t      dma,
    input  irq_cfg_t      icfg,
    input  logic          und_st,
    input  logic          ovf_st,
    output logic          tx_dma_req,
    output logic          rx_dma_req,
    output logic          tx_low,
    output logic          rx_high,
    output logic          irq
);

    assign tx_dma_req = dma.tx_en && lvl_at_most(8'(tx_lvl), dma.tx_code);
    assign rx_dma_req = dma.rx_en && lvl_at_least(8'(rx_lvl), dma.rx_code);
    assign tx_low     = lvl_at_most(8'(tx_lvl), icfg.tx_thr);
    assign rx_high    = lvl_at_least(8'(rx_lvl), icfg.rx_thr);
    assign irq        = (tx_low && icfg.empty_ie) || (und_st && icfg.und_ie)
                     || (rx_high && icfg.full_ie) || (ovf_st && icfg.ovf_ie);

endmodule

// File: rtl/afc_core.sv
module afc_core
    import afc_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int DEPTH      = 32,
    parameter int CLR_CYCLES = 4,
    parameter int ADDR_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_rd,
    output logic [31:0]          bus_rdata,
    input  logic                 tx_take,
    output logic [LANES*32-1:0]  tx_word,
    input  logic                 rx_put,
    input  logic [31:0]          rx_word,
    output logic                 tx_dma_req,
    output logic                 rx_dma_req,
    output logic                 irq
);

    localparam int LW  = $clog2(DEPTH) + 1;
    localparam int LPW = (LANES > 1) ? $clog2(LANES) : 1;

    localparam logic [ADDR_W-1:0] A_TXCTL  = ADDR_W'(OFF_TXCTL);
    localparam logic [ADDR_W-1:0] A_RXCTL  = ADDR_W'(OFF_RXCTL);
    localparam logic [ADDR_W-1:0] A_CKCTL  = ADDR_W'(OFF_CKCTL);
    localparam logic [ADDR_W-1:0] A_LEVEL  = ADDR_W'(OFF_LEVEL);
    localparam logic [ADDR_W-1:0] A_DMA    = ADDR_W'(OFF_DMA);
    localparam logic [ADDR_W-1:0] A_INTCTL = ADDR_W'(OFF_INTCTL);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_XFER   = ADDR_W'(OFF_XFER);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFF_CLEAR);
    localparam logic [ADDR_W-1:0] A_TXDATA = ADDR_W'(OFF_TXDATA);
    localparam logic [ADDR_W-1:0] A_RXDATA = ADDR_W'(OFF_RXDATA);

    // configuration and state
    logic [31:0] txctl_q, rxctl_q, ckctl_q;
    dma_cfg_t    dma_q;
    irq_cfg_t    icfg_q;
    logic        tx_run, rx_run;
    logic        und_st, ovf_st;

    // bus decode
    logic wr_txdata, wr_clear, wr_intctl, rd_rxdata;
    logic tx_clr_go, rx_clr_go, tx_busy, rx_busy, tx_flush, rx_flush;

    assign wr_txdata = bus_wr && (bus_addr == A_TXDATA);
    assign wr_clear  = bus_wr && (bus_addr == A_CLEAR);
    assign wr_intctl = bus_wr && (bus_addr == A_INTCTL);
    assign rd_rxdata = bus_rd && (bus_addr == A_RXDATA);
    assign tx_clr_go = wr_clear && bus_wdata[0];
    assign rx_clr_go = wr_clear && bus_wdata[1];
    assign tx_flush  = tx_clr_go || tx_busy;
    assign rx_flush  = rx_clr_go || rx_busy;

    afc_clr_timer #(.CYCLES(CLR_CYCLES)) u_tx_clr (
        .clk(clk), .rst(rst), .start(tx_clr_go), .busy(tx_busy)
    );
    afc_clr_timer #(.CYCLES(CLR_CYCLES)) u_rx_clr (
        .clk(clk), .rst(rst), .start(rx_clr_go), .busy(rx_busy)
    );

    // transmit lanes
    logic [LW-1:0]  tx_lvl   [LANES];
    logic [31:0]    lane_out [LANES];
    logic [LANES-1:0] lane_full, lane_empty, lane_acc;
    logic [LPW-1:0] wr_lane;
    logic           tx_pop_all, und_set;
    logic [LW-1:0]  tx_lvl_last;

    assign tx_lvl_last = tx_lvl[LANES-1];
    assign tx_pop_all  = tx_take && tx_run && !lane_empty[LANES-1] && !tx_flush;
    assign und_set     = tx_take && tx_run && lane_empty[LANES-1];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic lane_push;
        assign lane_push = wr_txdata && !tx_flush && (wr_lane == LPW'(k));
        afc_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst(rst), .flush(tx_flush),
            .push(lane_push), .din(bus_wdata), .pop(tx_pop_all),
            .dout(lane_out[k]), .level(tx_lvl[k]),
            .full(lane_full[k]), .empty(lane_empty[k]), .accept(lane_acc[k])
        );
        assign tx_word[32*k +: 32] = lane_out[k];
    end

    always_ff @(posedge clk) begin
        if (rst || tx_flush)
            wr_lane <= '0;
        else if (|lane_acc)
            wr_lane <= (wr_lane == LPW'(LANES - 1)) ? '0 : wr_lane + 1'b1;
    end

    // receive FIFO
    logic [LW-1:0] rx_lvl;
    logic [31:0]   rx_out;
    logic          rx_full, rx_empty, rx_acc, rx_push, ovf_set;

    assign rx_push = rx_put && rx_run && !rx_flush;
    assign ovf_set = rx_push && rx_full && !rd_rxdata;

    afc_fifo #(.W(32), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(rx_push), .din(rx_word), .pop(rd_rxdata && !rx_flush),
        .dout(rx_out), .level(rx_lvl),
        .full(rx_full), .empty(rx_empty), .accept(rx_acc)
    );

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            txctl_q <= '0;
            rxctl_q <= '0;
            ckctl_q <= '0;
            dma_q   <= '0;
            icfg_q  <= '0;
            tx_run  <= 1'b0;
            rx_run  <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_TXCTL:  txctl_q <= bus_wdata;
                A_RXCTL:  rxctl_q <= bus_wdata;
                A_CKCTL:  ckctl_q <= bus_wdata;
                A_DMA:    dma_q   <= '{rx_en: bus_wdata[24], rx_code: bus_wdata[20:16],
                                       tx_en: bus_wdata[8],  tx_code: bus_wdata[4:0]};
                A_INTCTL: icfg_q  <= '{rx_thr: bus_wdata[24:20], ovf_ie: bus_wdata[17],
                                       full_ie: bus_wdata[16],  tx_thr: bus_wdata[8:4],
                                       und_ie: bus_wdata[1],    empty_ie: bus_wdata[0]};
                A_XFER: begin
                    tx_run <= bus_wdata[0];
                    rx_run <= bus_wdata[1];
                end
                default: ;
            endcase
        end
    end

    // sticky error flags: setting wins over clearing
    always_ff @(posedge clk) begin
        if (rst) begin
            und_st <= 1'b0;
            ovf_st <= 1'b0;
        end else begin
            if (und_set)                            und_st <= 1'b1;
            else if (wr_intctl && bus_wdata[2])     und_st <= 1'b0;
            if (ovf_set)                            ovf_st <= 1'b1;
            else if (wr_intctl && bus_wdata[18])    ovf_st <= 1'b0;
        end
    end

    // level compares, requests, interrupt
    logic tx_low, rx_high;

    afc_flags #(.LW(LW)) u_flags (
        .tx_lvl(tx_lvl_last), .rx_lvl(rx_lvl), .dma(dma_q), .icfg(icfg_q),
        .und_st(und_st), .ovf_st(ovf_st),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .tx_low(tx_low), .rx_high(rx_high), .irq(irq)
    );

    // read side
    logic [31:0] lvl_word, stat_word;

    always_comb begin
        lvl_word = '0;
        for (int k = 0; k < LANES; k++) lvl_word[6*k +: 6] = 6'(tx_lvl[k]);
        lvl_word[29:24] = 6'(rx_lvl);
    end

    always_comb begin
        stat_word     = '0;
        stat_word[0]  = tx_low;
        stat_word[1]  = und_st;
        stat_word[16] = rx_high;
        stat_word[17] = ovf_st;
    end

    always_comb begin
        case (bus_addr)
            A_TXCTL:  bus_rdata = txctl_q;
            A_RXCTL:  bus_rdata = rxctl_q;
            A_CKCTL:  bus_rdata = ckctl_q;
            A_LEVEL:  bus_rdata = lvl_word;
            A_DMA:    bus_rdata = pack_dma(dma_q);
            A_INTCTL: bus_rdata = pack_irq(icfg_q);
            A_STATUS: bus_rdata = stat_word;
            A_XFER:   bus_rdata = {30'b0, rx_run, tx_run};
            A_CLEAR:  bus_rdata = {30'b0, rx_busy, tx_busy};
            A_RXDATA: bus_rdata = rx_empty ? 32'h0 : rx_out;
            default:  bus_rdata = 32'h0;
        endcase
    end

endmodule

// File: rtl/afc_core_chk.sv
module afc_core_chk #(
    parameter int DEPTH = 32,
    parameter int LW    = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_put,
    input logic          rx_run,
    input logic          rx_pop,
    input logic          rx_full,
    input logic          rx_flush,
    input logic [LW-1:0] rx_lvl,
    input logic          tx_take,
    input logic          tx_run,
    input logic          tx_busy,
    input logic [LW-1:0] tx_lvl_last,
    input logic          und_st,
    input logic          ovf_st,
    input logic          rx_dma_req,
    input logic          rx_dma_en
);

    // R7
    ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_st) |-> $past(rx_put && rx_run));

    // R9
    und_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(und_st) |-> $past(tx_take && tx_run));

    // R8
    full_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_full && rx_pop && rx_put && rx_run && !rx_flush) |=> (rx_lvl == LW'(DEPTH)));

    // R12
    clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
        tx_busy |-> (tx_lvl_last == '0));

    // R10
    rx_req_gate_chk: assert property (@(posedge clk) disable iff (rst)
        rx_dma_req |-> rx_dma_en);

    // R3
    rx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rx_lvl <= LW'(DEPTH));

endmodule

bind afc_core afc_core_chk #(.DEPTH(DEPTH), .LW($clog2(DEPTH) + 1)) u_chk (
    .clk(clk), .rst(rst),
    .rx_put(rx_put), .rx_run(rx_run), .rx_pop(rd_rxdata), .rx_full(rx_full),
    .rx_flush(rx_flush), .rx_lvl(rx_lvl),
    .tx_take(tx_take), .tx_run(tx_run), .tx_busy(tx_busy), .tx_lvl_last(tx_lvl_last),
    .und_st(und_st), .ovf_st(ovf_st),
    .rx_dma_req(rx_dma_req), .rx_dma_en(dma_q.rx_en)
);

// File: tb/afc_core_test.sv
module afc_core_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_rdata;
    logic         tx_take = 1'b0;
    logic [127:0] tx_word;
    logic         rx_put = 1'b0;
    logic [31:0]  rx_word = '0;
    logic         tx_dma_req, rx_dma_req, irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    afc_core uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tx_take(tx_take), .tx_word(tx_word), .rx_put(rx_put), .rx_word(rx_word),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reset_dut();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic take();
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    task automatic put(input logic [31:0] w);
        rx_put = 1'b1; rx_word = w;
        @(negedge clk);
        rx_put = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        reset_dut();
        rd(8'h00, d); chk("R1 txctl reset", d, 32'h0);
        rd(8'h0C, d); chk("R3 level reset", d, 32'h0);
        rd(8'h18, d); chk("R11 status reset", d, 32'h1);
        rd(8'h1C, d); chk("R2 xfer reset", d, 32'h0);
        rd(8'h20, d); chk("R12 clear reset", d, 32'h0);
        chk("R10 reqs reset", {30'b0, tx_dma_req, rx_dma_req}, 32'h0);
        chk("R11 irq reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        reset_dut();
        wr(8'h00, 32'hA5A5_5A5A); wr(8'h04, 32'h1234_5678); wr(8'h08, 32'h0F0F_F0F0);
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R1 txctl", d, 32'hA5A5_5A5A);
        rd(8'h04, d); chk("R1 rxctl", d, 32'h1234_5678);
        rd(8'h08, d); chk("R1 ckctl", d, 32'h0F0F_F0F0);
        rd(8'h10, d); chk("R1 dma fields", d, 32'h011F_011F);
        rd(8'h14, d); chk("R1 intctl fields", d, 32'h01F3_01F3);
        rd(8'h24, d); chk("R1 txdata reads 0", d, 32'h0);
        rd(8'h2C, d); chk("R1 unmapped", d, 32'h0);
    endtask

    task automatic t_start_bits();
        logic [31:0] d;
        reset_dut();
        for (int i = 0; i < 4; i++) wr(8'h24, 32'h10 + i);
        take();
        rd(8'h0C, d); chk("R2 take while stopped keeps levels", d, 32'h0004_1041);
        rd(8'h18, d); chk("R2 no underrun while stopped", d & 32'h2, 32'h0);
        put(32'h77);
        rd(8'h0C, d); chk("R2 put while stopped ignored", d[29:24], 32'h0);
        wr(8'h1C, 32'h3);
        rd(8'h1C, d); chk("R2 both run", d, 32'h3);
        wr(8'h1C, 32'h1);
        rd(8'h1C, d); chk("R2 rx stopped", d, 32'h1);
    endtask

    task automatic t_tx_frames();
        logic [31:0] d;
        reset_dut();
        for (int i = 0; i < 8; i++) wr(8'h24, 32'h1000 + i);
        rd(8'h0C, d); chk("R3 round robin levels", d, 32'h0008_2082);
        wr(8'h1C, 32'h1);
        for (int k = 0; k < 4; k++) chk("R4 first frame lane", tx_word[32*k +: 32], 32'h1000 + k);
        take();
        for (int k = 0; k < 4; k++) chk("R4 second frame lane", tx_word[32*k +: 32], 32'h1004 + k);
        rd(8'h0C, d); chk("R4 one popped from each lane", d, 32'h0004_1041);
    endtask

    task automatic t_tx_full();
        logic [31:0] d;
        reset_dut();
        for (int i = 0; i < 128; i++) wr(8'h24, i);
        rd(8'h0C, d); chk("R3 all lanes full", d, 32'h0082_0820);
        wr(8'h24, 32'hDEAD);
        rd(8'h0C, d); chk("R5 write to full lane dropped", d, 32'h0082_0820);
        wr(8'h1C, 32'h1);
        take();
        wr(8'h24, 32'hBEEF);
        rd(8'h0C, d); chk("R5 pointer held at lane 0", d, 32'h007D_F7E0);
    endtask

    task automatic t_underrun();
        logic [31:0] d;
        reset_dut();
        wr(8'h1C, 32'h1);
        take();
        rd(8'h18, d); chk("R9 underrun set", d, 32'h3);
        chk("R11 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h14, 32'h2);
        chk("R11 irq from underrun", {31'b0, irq}, 32'h1);
        wr(8'h14, 32'h6);
        rd(8'h18, d); chk("R9 underrun cleared", d, 32'h1);
        chk("R11 irq drops", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_rx_overflow();
        logic [31:0] d;
        reset_dut();
        wr(8'h1C, 32'h2);
        for (int i = 0; i < 32; i++) put(32'd100 + i);
        put(32'd999);
        rd(8'h18, d); chk("R7 overflow flagged", d & 32'h2_0000, 32'h2_0000);
        rd(8'h0C, d); chk("R7 level stays 32", d[29:24], 32'd32);
        for (int i = 0; i < 32; i++) begin
            rd(8'h28, d);
            if (i == 0)  chk("R6 oldest first", d, 32'd100);
            if (i == 31) chk("R7 extra word dropped", d, 32'd131);
        end
        rd(8'h28, d); chk("R6 empty reads 0", d, 32'h0);
        rd(8'h18, d); chk("R7 sticky after drain", d & 32'h2_0000, 32'h2_0000);
        wr(8'h14, 32'h0004_0000);
        rd(8'h18, d); chk("R7 overflow cleared", d & 32'h2_0000, 32'h0);
    endtask

    task automatic t_full_swap();
        logic [31:0] d;
        reset_dut();
        wr(8'h1C, 32'h2);
        for (int i = 0; i < 32; i++) put(32'd200 + i);
        rx_put = 1'b1; rx_word = 32'd555; bus_rd = 1'b1; bus_addr = 8'h28;
        #1 d = bus_rdata;
        @(negedge clk);
        rx_put = 1'b0; bus_rd = 1'b0;
        chk("R8 pop returns oldest", d, 32'd200);
        rd(8'h0C, d); chk("R8 level stays 32", d[29:24], 32'd32);
        rd(8'h18, d); chk("R8 no overflow", d & 32'h2_0000, 32'h0);
        for (int i = 0; i < 32; i++) begin
            rd(8'h28, d);
            if (i == 31) chk("R8 arriving word kept", d, 32'd555);
        end
    endtask

    task automatic t_dma();
        reset_dut();
        wr(8'h1C, 32'h3);
        wr(8'h10, 32'h0102_0000);
        put(32'h1); put(32'h2);
        chk("R10 rx req below level", {31'b0, rx_dma_req}, 32'h0);
        put(32'h3);
        chk("R10 rx req at level", {31'b0, rx_dma_req}, 32'h1);
        chk("R10 tx req disabled", {31'b0, tx_dma_req}, 32'h0);
        wr(8'h10, 32'h0102_0101);
        chk("R10 tx req empty", {31'b0, tx_dma_req}, 32'h1);
        for (int i = 0; i < 12; i++) wr(8'h24, i);
        chk("R10 tx req above level", {31'b0, tx_dma_req}, 32'h0);
        take();
        chk("R10 tx req at level", {31'b0, tx_dma_req}, 32'h1);
    endtask

    task automatic t_thresholds();
        logic [31:0] d;
        reset_dut();
        wr(8'h14, 32'h1);
        chk("R11 irq on tx low", {31'b0, irq}, 32'h1);
        for (int i = 0; i < 8; i++) wr(8'h24, i);
        chk("R11 irq off above thr", {31'b0, irq}, 32'h0);
        wr(8'h14, 32'h0011_0000);
        wr(8'h1C, 32'h2);
        put(32'h9);
        rd(8'h18, d); chk("R11 rx below thr", d & 32'h1_0000, 32'h0);
        put(32'hA);
        rd(8'h18, d); chk("R11 rx at thr", d & 32'h1_0000, 32'h1_0000);
        chk("R11 irq on rx full", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        int ones;
        reset_dut();
        for (int i = 0; i < 8; i++) wr(8'h24, i);
        wr(8'h1C, 32'h2);
        put(32'h5);
        wr(8'h20, 32'h1);
        ones = 0;
        for (int i = 0; i < 8; i++) begin
            rd(8'h20, d);
            if (d[0]) ones++;
        end
        chk("R12 tx clear busy cycles", ones, 32'd4);
        rd(8'h0C, d); chk("R12 tx flushed rx kept", d, 32'h0100_0000);
        wr(8'h20, 32'h2);
        rd(8'h20, d); chk("R12 rx clear reads 1", d, 32'h2);
        repeat (4) @(negedge clk);
        rd(8'h20, d); chk("R12 rx clear done", d, 32'h0);
        rd(8'h0C, d); chk("R12 rx flushed", d, 32'h0);
        wr(8'h24, 32'h42);
        rd(8'h0C, d); chk("R12 lane 0 after clear", d, 32'h1);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_regs();
        t_start_bits();
        t_tx_frames();
        t_tx_full();
        t_underrun();
        t_rx_overflow();
        t_full_swap();
        t_dma();
        t_thresholds();
        t_clear();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule